// File: doc/BRIEF.md
# Banked Memory Mapper with I/O Port Decode

This block sits between an 8-bit CPU and its memories. The CPU has a 16-bit memory address and a separate 8-bit I/O port space. The block turns each memory address into a ROM page address and owns an 8 KB work RAM in the top quarter of the memory map. The last eight bytes of that RAM double as mapper registers. A write there updates the RAM byte and, for some offsets, the page selection of a 16 KB ROM window.

The lowest window, 0x0000–0x3FFF, always shows ROM page 0. The windows at 0x4000 and 0x8000 each show a page chosen by a register. On the I/O side, the port address is reduced to three bits. The result drives one-cycle write strobes to a sound generator and to the video data and control ports, and it loads an I/O control register. The ROM, the sound generator and the video chip are outside the block. The ROM is assumed to return data combinationally for `rom_addr`.

Top module: `bank_mapper`

## Requirements
- R1: After reset, the 0x4000 window maps ROM page 1, the 0x8000 window maps page 2, `ioctl_q` is 0, and `mem_rdata`, `anomaly` and all strobes are 0.
- R2: `rom_addr` is combinational and equals {page, `mem_addr[13:0]`}. The page is 0 for addresses 0x0000–0x3FFF.
- R3: A memory write to 0xFFFE sets the page of the 0x4000 window, and a write to 0xFFFF sets the page of the 0x8000 window. In both cases the stored page is the data byte ANDed with `cfg_bank_mask`, and it takes effect from the next cycle.
- R4: A memory write at 0xFFF8–0xFFFF also stores the unmasked data byte in work RAM, so a later read of the same address returns that byte.
- R5: A memory write at 0xC000 or above stores into work RAM at index `mem_addr[12:0]`, so 0xE000–0xFFFF mirrors 0xC000–0xDFFF.
- R6: Memory writes below 0xC000 change neither work RAM nor the mapping.
- R7: Writes to 0xFFFC and 0xFFFD do not change the mapping. A nonzero write to 0xFFFD raises `anomaly` for exactly the next cycle, and a zero write to it does not.
- R8: A read sampled with `mem_rd` returns its byte on `mem_rdata` one cycle later: ROM data below 0xC000 and work RAM data at 0xC000 and above.
- R9: I/O ports are decoded on `{io_addr[7], io_addr[6], io_addr[0]}` only. A write whose reduced code is 0x01 loads `ioctl_q` on the next cycle.
- R10: An I/O write with reduced code 0x40 or 0x41 pulses `snd_we` for one cycle with `snd_data`, but only when `cfg_sound_en` is 1.
- R11: Reduced code 0x80 pulses `vdp_data_we`, and reduced code 0x81 pulses `vdp_ctrl_we`, each for one cycle with the byte on `vdp_wdata`.
- R12: Reduced codes 0x00 and 0xC0/0xC1 produce no strobe and leave `ioctl_q` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sound_en | input | 1 | Enables forwarding to the sound generator |
| cfg_bank_mask | input | PAGE_W | Mask applied to page numbers, set from the ROM size |
| mem_addr | input | 16 | CPU memory address |
| mem_wr | input | 1 | Memory write request |
| mem_rd | input | 1 | Memory read request |
| mem_wdata | input | 8 | Memory write data |
| mem_rdata | output | 8 | Read data, one cycle after the request |
| rom_addr | output | PAGE_W+14 | Mapped ROM byte address |
| rom_rdata | input | 8 | ROM data for `rom_addr` |
| io_addr | input | 8 | CPU I/O port address |
| io_wr | input | 1 | I/O write request |
| io_wdata | input | 8 | I/O write data |
| ioctl_q | output | 8 | I/O control register |
| snd_we | output | 1 | Sound generator write strobe |
| snd_data | output | 8 | Sound generator data |
| vdp_data_we | output | 1 | Video data port strobe |
| vdp_ctrl_we | output | 1 | Video control port strobe |
| vdp_wdata | output | 8 | Video port data |
| anomaly | output | 1 | Pulse on a nonzero write to the slot 0 page register |

## Verification
The hardest case to reach is a single write that must land in two places: the RAM byte at 0xFFFE and the masked page register. Seeing both requires choosing a data byte whose bits above the mask are set. The bench then reads 0xFFFE back through the RAM path, which must return the raw byte, and reads through the 0x4000 window, which must use the masked page. The I/O decode is driven with aliased port numbers such as 0x3F, 0x7F and 0xBE, so that bits 5:1 of the port address are shown to be ignored.

// File: rtl/bank_mapper.sv
module bank_mapper #(
  parameter int PAGE_W = 8,
  parameter int RAM_AW = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_sound_en,
  input  logic [PAGE_W-1:0] cfg_bank_mask,
  input  logic [15:0]       mem_addr,
  input  logic              mem_wr,
  input  logic              mem_rd,
  input  logic [7:0]        mem_wdata,
  output logic [7:0]        mem_rdata,
  output logic [PAGE_W+13:0] rom_addr,
  input  logic [7:0]        rom_rdata,
  input  logic [7:0]        io_addr,
  input  logic              io_wr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        ioctl_q,
  output logic              snd_we,
  output logic [7:0]        snd_data,
  output logic              vdp_data_we,
  output logic              vdp_ctrl_we,
  output logic [7:0]        vdp_wdata,
  output logic              anomaly
);
  localparam int RAM_N = 2 ** RAM_AW;

  logic [7:0]        ram [RAM_N];
  logic [PAGE_W-1:0] win1_pg, win2_pg, cur_pg, wr_pg;
  logic [2:0]        port;
  logic              unused_io;

  wire ram_hit = mem_addr[15:14] == 2'b11;
  wire reg_wr  = mem_wr && (mem_addr[15:3] == 13'h1FFF);

  assign port      = {io_addr[7], io_addr[6], io_addr[0]};
  assign unused_io = ^io_addr[5:1];
  assign wr_pg     = PAGE_W'(mem_wdata) & cfg_bank_mask;

  always_comb begin
    case (mem_addr[15:14])
      2'b01:   cur_pg = win1_pg;
      2'b10:   cur_pg = win2_pg;
      default: cur_pg = '0;
    endcase
  end
  assign rom_addr = {cur_pg, mem_addr[13:0]};

  always_ff @(posedge clk)
    if (mem_wr && ram_hit) ram[mem_addr[RAM_AW-1:0]] <= mem_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win1_pg <= PAGE_W'(1);
      win2_pg <= PAGE_W'(2);
      anomaly <= 1'b0;
      mem_rdata <= 8'h00;
    end else begin
      if (reg_wr && mem_addr[2:0] == 3'h6) win1_pg <= wr_pg;
      if (reg_wr && mem_addr[2:0] == 3'h7) win2_pg <= wr_pg;
      anomaly <= reg_wr && mem_addr[2:0] == 3'h5 && mem_wdata != 8'h00;
      if (mem_rd) mem_rdata <= ram_hit ? ram[mem_addr[RAM_AW-1:0]] : rom_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ioctl_q     <= 8'h00;
      snd_we      <= 1'b0;
      vdp_data_we <= 1'b0;
      vdp_ctrl_we <= 1'b0;
      snd_data    <= 8'h00;
      vdp_wdata   <= 8'h00;
    end else begin
      snd_we      <= io_wr && cfg_sound_en && port[2:1] == 2'b01;
      vdp_data_we <= io_wr && port == 3'b100;
      vdp_ctrl_we <= io_wr && port == 3'b101;
      if (io_wr && port == 3'b001) ioctl_q <= io_wdata;
      if (io_wr && cfg_sound_en && port[2:1] == 2'b01) snd_data <= io_wdata;
      if (io_wr && port[2:1] == 2'b10) vdp_wdata <= io_wdata;
    end
  end
endmodule

// File: rtl/bank_mapper_chk.sv
module bank_mapper_chk #(
  parameter int PAGE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_sound_en,
  input logic [PAGE_W-1:0] cfg_bank_mask,
  input logic [15:0]       mem_addr,
  input logic              mem_wr,
  input logic [7:0]        mem_wdata,
  input logic [PAGE_W+13:0] rom_addr,
  input logic [7:0]        io_addr,
  input logic              io_wr,
  input logic [7:0]        ioctl_q,
  input logic              snd_we,
  input logic              vdp_data_we,
  input logic              vdp_ctrl_we,
  input logic              anomaly
);
  assert_rom_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rom_addr[13:0] == mem_addr[13:0]);

  assert_low_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_addr[15:14] == 2'b00 |-> rom_addr[PAGE_W+13:14] == '0);

  assert_page_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mem_wr) && $past(mem_addr) == 16'hFFFE && mem_addr[15:14] == 2'b01)
      |-> rom_addr[PAGE_W+13:14] == (PAGE_W'($past(mem_wdata)) & $past(cfg_bank_mask)));

  assert_anomaly_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    anomaly |-> ($past(mem_wr) && $past(mem_addr) == 16'hFFFD && $past(mem_wdata) != 8'h00));

  assert_ioctl_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ioctl_q) |-> ($past(io_wr) && {$past(io_addr[7]), $past(io_addr[6]), $past(io_addr[0])} == 3'b001));

  assert_sound_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    snd_we |-> ($past(cfg_sound_en) && $past(io_wr)));

  assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({snd_we, vdp_data_we, vdp_ctrl_we}));
endmodule

bind bank_mapper bank_mapper_chk #(.PAGE_W(PAGE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_sound_en(cfg_sound_en), .cfg_bank_mask(cfg_bank_mask),
  .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_wdata(mem_wdata), .rom_addr(rom_addr),
  .io_addr(io_addr), .io_wr(io_wr), .ioctl_q(ioctl_q), .snd_we(snd_we),
  .vdp_data_we(vdp_data_we), .vdp_ctrl_we(vdp_ctrl_we), .anomaly(anomaly));

// File: tb/bank_mapper_tb_top.sv
module bank_mapper_tb_top;
  localparam int PW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_sound_en = 1'b1;
  logic [PW-1:0] cfg_bank_mask = 8'h1F;
  logic [15:0] mem_addr = '0;
  logic mem_wr = 0, mem_rd = 0, io_wr = 0;
  logic [7:0] mem_wdata = 0, io_addr = 0, io_wdata = 0;
  logic [7:0] mem_rdata, ioctl_q, snd_data, vdp_wdata, rom_rdata;
  logic [PW+13:0] rom_addr;
  logic snd_we, vdp_data_we, vdp_ctrl_we, anomaly;
  int checks = 0, fails = 0;
  logic [7:0] rd;
  logic [7:0] exp_ctl = 8'h00;

  always #4 clk = ~clk;

  assign rom_rdata = rom_addr[7:0] ^ rom_addr[PW+13:14];

  bank_mapper #(.PAGE_W(PW), .RAM_AW(13)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_sound_en(cfg_sound_en), .cfg_bank_mask(cfg_bank_mask),
    .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .rom_addr(rom_addr), .rom_rdata(rom_rdata),
    .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata), .ioctl_q(ioctl_q),
    .snd_we(snd_we), .snd_data(snd_data), .vdp_data_we(vdp_data_we),
    .vdp_ctrl_we(vdp_ctrl_we), .vdp_wdata(vdp_wdata), .anomaly(anomaly));

  typedef struct packed {
    logic [7:0] port;
    logic [7:0] data;
    logic       sen;
    logic [2:0] stb;
    logic       ctl;
  } io_vec_t;

  localparam io_vec_t IO_TABLE [10] = '{
    '{8'h01, 8'h5A, 1'b1, 3'b000, 1'b1},
    '{8'h3F, 8'hA5, 1'b1, 3'b000, 1'b1},
    '{8'h40, 8'h11, 1'b1, 3'b100, 1'b0},
    '{8'h7F, 8'h22, 1'b1, 3'b100, 1'b0},
    '{8'h41, 8'h33, 1'b0, 3'b000, 1'b0},
    '{8'h80, 8'h44, 1'b1, 3'b010, 1'b0},
    '{8'hBE, 8'h55, 1'b1, 3'b010, 1'b0},
    '{8'h81, 8'h66, 1'b1, 3'b001, 1'b0},
    '{8'hC1, 8'h77, 1'b1, 3'b000, 1'b0},
    '{8'h00, 8'h88, 1'b1, 3'b000, 1'b0}
  };

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic mem_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); mem_addr = a; mem_wdata = d; mem_wr = 1;
    @(negedge clk); mem_wr = 0;
  endtask

  task automatic mem_read(input logic [15:0] a, output logic [7:0] q);
    @(negedge clk); mem_addr = a; mem_rd = 1;
    @(negedge clk); mem_rd = 0; q = mem_rdata;
  endtask

  task automatic io_write(input logic [7:0] p, input logic [7:0] d);
    @(negedge clk); io_addr = p; io_wdata = d; io_wr = 1;
    @(negedge clk); io_wr = 0;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(ioctl_q == 0 && mem_rdata == 0 && !anomaly, "R1 regs", {ioctl_q, mem_rdata}, 0);
    check({snd_we, vdp_data_we, vdp_ctrl_we} == 0, "R1 strobes", {snd_we, vdp_data_we, vdp_ctrl_we}, 0);
    mem_addr = 16'h4567; #1;
    check(rom_addr == {8'd1, 14'h0567}, "R1 window1 page", rom_addr, {8'd1, 14'h0567});
    mem_addr = 16'hB001; #1;
    check(rom_addr == {8'd2, 14'h3001}, "R1 window2 page", rom_addr, {8'd2, 14'h3001});
    mem_addr = 16'h3ABC; #1;
    check(rom_addr == {8'd0, 14'h3ABC}, "R2 window0 page", rom_addr, {8'd0, 14'h3ABC});

    // I/O table: R9 R10 R11 R12
    foreach (IO_TABLE[i]) begin
      cfg_sound_en = IO_TABLE[i].sen;
      io_write(IO_TABLE[i].port, IO_TABLE[i].data);
      if (IO_TABLE[i].ctl) exp_ctl = IO_TABLE[i].data;
      check({snd_we, vdp_data_we, vdp_ctrl_we} == IO_TABLE[i].stb, "R10/R11/R12 strobe",
            {snd_we, vdp_data_we, vdp_ctrl_we}, IO_TABLE[i].stb);
      check(ioctl_q == exp_ctl, "R9/R12 ioctl", ioctl_q, exp_ctl);
      if (IO_TABLE[i].stb[2])
        check(snd_data == IO_TABLE[i].data, "R10 data", snd_data, IO_TABLE[i].data);
      if (IO_TABLE[i].stb[1:0] != 0)
        check(vdp_wdata == IO_TABLE[i].data, "R11 data", vdp_wdata, IO_TABLE[i].data);
      @(negedge clk);
      check({snd_we, vdp_data_we, vdp_ctrl_we} == 0, "R11 one-cycle", {snd_we, vdp_data_we, vdp_ctrl_we}, 0);
    end
    cfg_sound_en = 1;

    // R8 ROM read latency
    mem_read(16'h4123, rd);
    check(rd == (8'h23 ^ 8'd1), "R8 rom read", rd, 8'h23 ^ 8'd1);

    // R3 + R4 masked page, raw RAM byte
    mem_write(16'hFFFE, 8'h25);
    mem_addr = 16'h4010; #1;
    check(rom_addr == {8'h05, 14'h0010}, "R3 masked page1", rom_addr, {8'h05, 14'h0010});
    mem_write(16'hFFFF, 8'hE3);
    mem_addr = 16'h8020; #1;
    check(rom_addr == {8'h03, 14'h0020}, "R3 masked page2", rom_addr, {8'h03, 14'h0020});
    mem_read(16'hFFFE, rd);
    check(rd == 8'h25, "R4 raw byte in RAM", rd, 8'h25);
    mem_read(16'h4123, rd);
    check(rd == (8'h23 ^ 8'h05), "R8 rom read new page", rd, 8'h23 ^ 8'h05);

    // R5 RAM and mirror
    mem_write(16'hC010, 8'h9C);
    mem_read(16'hE010, rd);
    check(rd == 8'h9C, "R5 mirror", rd, 8'h9C);
    mem_write(16'hFFF0, 8'h6B);
    mem_read(16'hDFF0, rd);
    check(rd == 8'h6B, "R5 mirror low", rd, 8'h6B);

    // R6 write below C000 ignored
    mem_write(16'h8010, 8'h00);
    mem_write(16'h0010, 8'h00);
    mem_read(16'hC010, rd);
    check(rd == 8'h9C, "R6 RAM untouched", rd, 8'h9C);
    mem_addr = 16'h8020; #1;
    check(rom_addr == {8'h03, 14'h0020}, "R6 map untouched", rom_addr, {8'h03, 14'h0020});

    // R7 control/slot0 registers
    mem_write(16'hFFFD, 8'h00);
    check(anomaly == 0, "R7 zero no anomaly", anomaly, 0);
    mem_write(16'hFFFD, 8'h07);
    check(anomaly == 1, "R7 anomaly pulse", anomaly, 1);
    @(negedge clk);
    check(anomaly == 0, "R7 anomaly one cycle", anomaly, 0);
    mem_write(16'hFFFC, 8'h80);
    mem_addr = 16'h0100; #1;
    check(rom_addr == {8'h00, 14'h0100}, "R7 window0 unchanged", rom_addr, {8'h00, 14'h0100});
    mem_addr = 16'h4100; #1;
    check(rom_addr == {8'h05, 14'h0100}, "R7 window1 unchanged", rom_addr, {8'h05, 14'h0100});
    mem_read(16'hFFFD, rd);
    check(rd == 8'h07, "R4 slot0 byte in RAM", rd, 8'h07);

    // R1 reset again restores pages
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    mem_addr = 16'h4000; #1;
    check(rom_addr == {8'd1, 14'h0}, "R1 page1 after reset", rom_addr, {8'd1, 14'h0});
    check(ioctl_q == 0, "R1 ioctl after reset", ioctl_q, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule